// File: doc/BRIEF.md
# Sectioned Lookahead Carry Adder

This block adds two 40-bit unsigned words and a carry-in, producing a 40-bit sum and a carry-out. The word is cut into four 10-bit sections. Inside a section, the carry into every stage is formed at once from the generate and propagate terms of the stages below it and the section's own carry-in. No stage waits for the stage beneath it. Between sections, the carry is passed on one section at a time. The longest carry path therefore grows with the number of sections and not with the number of bits.

The adder core is combinational. An output register, selected by a parameter and on by default, stores the sum and carry-out on each rising clock edge. This gives a single-cycle timing path that can be checked. With the register on, a result appears one clock after its operands. An asynchronous active-low reset clears the register.

Top module: `sect_cla_adder`

## Requirements
- R1: `{c_out, sum_out}` equals the 41-bit unsigned value `a_in + b_in + c_in`, for any operands and either carry-in.
- R2: The word is split into four 10-bit sections. The carry entering section k (k = 1..3, which starts at bit 10k) equals bit 10k of the exact sum of the low 10k bits of both operands plus `c_in`.
- R3: A carry that enters a section in which every bit pair differs (`a ^ b` all ones) passes straight through it. All-ones plus zero with `c_in` = 1 gives sum 0 and `c_out` = 1.
- R4: A section whose top bit pair is 1 and 1 sends a carry to the next section whatever its carry-in is.
- R5: `c_out` is the carry that leaves the most significant section (bits 39..30).
- R6: With the output register enabled, the outputs show the result of the operands present at the previous rising edge, a latency of one cycle.
- R7: While `rst_n` is low, `sum_out` and `c_out` are both 0.
- R8: With `c_in` = 0 and no bit position where both operands are 1, `sum_out` equals `a_in | b_in` and `c_out` is 0.
- R9: Adding 1 to a value whose low 10k bits are all ones and whose higher bits are zero gives exactly 2^(10k), for k = 1..3. The carry stops at the first zero bit above the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a_in | input | 40 | First operand |
| b_in | input | 40 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | 40 | Sum, registered when the output register is enabled |
| c_out | output | 1 | Carry out of bit 39 |

## Verification
The bench targets carries that must cross section boundaries. It adds all-ones plus a carry-in, and it adds 1 to runs of ones that end exactly at bits 9, 19 and 29. A design with a broken link between sections would leave the upper section unchanged, and one with a wrong in-section lookahead term would flip single sum bits. Alternating bit patterns and operands with no common ones check that no carry appears where none is due. Operands that generate at the top of a section check that a carry is not dropped when the section's carry-in is 0. Random operands with both carry-in values complete the arithmetic check, and a check held during reset confirms the cleared outputs.

// File: rtl/sca_pkg.sv
package sca_pkg;
  localparam int unsigned DEF_WIDTH = 40;
  localparam int unsigned DEF_SEC_W = 10;

  // Group terms a section hands to the inter-section link
  typedef struct packed {
    logic gen;   // section creates a carry on its own
    logic prop;  // section passes an incoming carry through
  } grp_t;
endpackage

// File: rtl/sca_pg.sv
module sca_pg #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);
  assign g = a & b;
  assign p = a ^ b;
endmodule

// File: rtl/sca_section.sv
module sca_section
  import sca_pkg::*;
#(
  parameter int unsigned SW = 10
) (
  input  logic [SW-1:0] g,
  input  logic [SW-1:0] p,
  input  logic          cin,
  output logic [SW-1:0] s,
  output grp_t          grp
);
  logic [SW-1:0] cy;

  // Each stage's carry is an OR of independent product terms: one per
  // lower originating stage (or the section carry-in), ANDed with every
  // propagate between the origin and the stage.
  always_comb begin
    logic acc;
    logic hit;
    for (int j = 0; j < SW; j++) begin
      acc = cin;
      for (int m = 0; m < j; m++) acc = acc & p[m];
      hit = acc;
      for (int k = 0; k < j; k++) begin
        acc = g[k];
        for (int m = k + 1; m < j; m++) acc = acc & p[m];
        hit = hit | acc;
      end
      cy[j] = hit;
    end
  end

  // Group generate: a carry leaves the top stage with no carry-in help
  always_comb begin
    logic acc;
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < SW; k++) begin
      acc = g[k];
      for (int m = k + 1; m < SW; m++) acc = acc & p[m];
      hit = hit | acc;
    end
    grp.gen  = hit;
    grp.prop = &p;
  end

  assign s = p ^ cy;
endmodule

// File: rtl/sca_link.sv
module sca_link
  import sca_pkg::*;
(
  input  grp_t grp,
  input  logic cin,
  output logic cout
);
  assign cout = grp.gen | (grp.prop & cin);
endmodule

// File: rtl/sect_cla_adder.sv
module sect_cla_adder
  import sca_pkg::*;
#(
  parameter int unsigned WIDTH   = DEF_WIDTH,
  parameter int unsigned SEC_W   = DEF_SEC_W,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum_out,
  output logic             c_out
);
  localparam int unsigned NSEC = WIDTH / SEC_W;

  logic [WIDTH-1:0] g_w;
  logic [WIDTH-1:0] p_w;
  logic [WIDTH-1:0] sum_d;
  logic [NSEC:0]    sec_c;
  grp_t             grp_w [NSEC];

  sca_pg #(.W(WIDTH)) u_pg (
    .a (a_in),
    .b (b_in),
    .g (g_w),
    .p (p_w)
  );

  assign sec_c[0] = c_in;

  for (genvar k = 0; k < NSEC; k++) begin : g_sec
    sca_section #(.SW(SEC_W)) u_section (
      .g   (g_w[k*SEC_W +: SEC_W]),
      .p   (p_w[k*SEC_W +: SEC_W]),
      .cin (sec_c[k]),
      .s   (sum_d[k*SEC_W +: SEC_W]),
      .grp (grp_w[k])
    );
    sca_link u_link (
      .grp  (grp_w[k]),
      .cin  (sec_c[k]),
      .cout (sec_c[k+1])
    );
  end

  if (OUT_REG) begin : g_oreg
    logic [WIDTH-1:0] sum_q;
    logic             cy_q;
    logic             ld_en;

    assign ld_en = 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
        cy_q  <= 1'b0;
      end else if (ld_en) begin
        sum_q <= sum_d;
        cy_q  <= sec_c[NSEC];
      end
    end

    assign sum_out = sum_q;
    assign c_out   = cy_q;
  end else begin : g_comb
    assign sum_out = sum_d;
    assign c_out   = sec_c[NSEC];
  end
endmodule

// File: rtl/sca_checker.sv
module sca_checker #(
  parameter int unsigned WIDTH   = 40,
  parameter int unsigned SEC_W   = 10,
  parameter bit          OUT_REG = 1'b1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [WIDTH-1:0]         a_in,
  input logic [WIDTH-1:0]         b_in,
  input logic                     c_in,
  input logic [WIDTH-1:0]         sum_out,
  input logic                     c_out,
  input logic [WIDTH/SEC_W:0]     sec_c
);
  localparam int unsigned NSEC = WIDTH / SEC_W;

  // R2: every inter-section carry matches exact low-part arithmetic
  for (genvar k = 1; k < NSEC; k++) begin : g_secchk
    localparam int unsigned LOW = k * SEC_W;
    logic [LOW:0] part;
    assign part = {1'b0, a_in[LOW-1:0]} + {1'b0, b_in[LOW-1:0]} + {{LOW{1'b0}}, c_in};
    assert_sec_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sec_c[k] == part[LOW]);
  end

  if (OUT_REG) begin : g_reg_chk
    // R1 / R6: registered result equals behavioural sum one cycle later
    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> {c_out, sum_out} ==
        ({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + {{WIDTH{1'b0}}, $past(c_in)}));
    // R3: full propagate with carry-in wraps to zero and carries out
    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((&(a_in ^ b_in)) && c_in) |=> (sum_out == '0) && c_out);
    // R8: no generating bit and no carry-in means no carry anywhere
    assert_nocarry_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((a_in & b_in) == '0) && !c_in) |=> (sum_out == $past(a_in | b_in)) && !c_out);
    // R5: top bit pair both one forces a carry out
    assert_topgen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (a_in[WIDTH-1] && b_in[WIDTH-1]) |=> c_out);
  end else begin : g_comb_chk
    assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
      {c_out, sum_out} ==
        ({1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in}));
    assert_topgen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (a_in[WIDTH-1] && b_in[WIDTH-1]) |-> c_out);
  end

  // R4: a section generating at its top bit feeds a carry upward
  for (genvar k = 0; k < NSEC - 1; k++) begin : g_gen_chk
    assert_secgen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_in[k*SEC_W + SEC_W - 1] && b_in[k*SEC_W + SEC_W - 1]) |-> sec_c[k+1]);
  end

  // R7: outputs are cleared while reset is held
  if (OUT_REG) begin : g_rst_chk
    assert_reset_R7: assert property (@(posedge clk)
      !rst_n |-> (sum_out == '0) && !c_out);
  end
endmodule

bind sect_cla_adder sca_checker #(
  .WIDTH   (WIDTH),
  .SEC_W   (SEC_W),
  .OUT_REG (OUT_REG)
) u_sca_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .a_in    (a_in),
  .b_in    (b_in),
  .c_in    (c_in),
  .sum_out (sum_out),
  .c_out   (c_out),
  .sec_c   (sec_c)
);

// File: tb/sect_cla_adder_bench.sv
module sect_cla_adder_bench;
  localparam int W  = 40;
  localparam int SW = 10;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in;
  logic [W-1:0] b_in;
  logic         c_in;
  logic [W-1:0] sum_out;
  logic         c_out;

  int n_chk;
  int n_fail;
  bit done;

  sect_cla_adder u_sect_cla_adder (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .c_in    (c_in),
    .sum_out (sum_out),
    .c_out   (c_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; the register captures at the next rising
  // edge; sample at the following falling edge.
  task automatic add_chk(input string req, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic c);
    logic [W:0] exp;
    a_in = a; b_in = b; c_in = c;
    exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    @(negedge clk);
    check(req, {c_out, sum_out}, exp);
  endtask

  task automatic t_reset;
    a_in = '1; b_in = '1; c_in = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R7", {c_out, sum_out}, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_latency;
    // R6: a new operand pair shows up only after the next rising edge
    a_in = 40'd5; b_in = 40'd7; c_in = 1'b0;
    @(negedge clk);
    a_in = 40'd100; b_in = 40'd23;
    #2;
    check("R6", {c_out, sum_out}, 41'd12);
    @(negedge clk);
    check("R6", {c_out, sum_out}, 41'd123);
  endtask

  task automatic t_wrap;
    add_chk("R3", '1, '0, 1'b1);
    check("R5", {40'd0, c_out}, 41'd1);
    add_chk("R3", 40'hAAAAAAAAAA, 40'h5555555555, 1'b1);
    add_chk("R1", '1, '1, 1'b1);
  endtask

  task automatic t_boundary;
    for (int k = 1; k < W / SW; k++) begin
      logic [W-1:0] run;
      run = (40'd1 << (k * SW)) - 40'd1;
      add_chk("R9", run, 40'd1, 1'b0);
      check("R9", {c_out, sum_out}, {1'b0, 40'd1 << (k * SW)});
      add_chk("R2", run, '0, 1'b1);
    end
  endtask

  task automatic t_nocarry;
    add_chk("R8", 40'hAAAAAAAAAA, 40'h5555555555, 1'b0);
    check("R8", {c_out, sum_out}, {1'b0, 40'hFFFFFFFFFF});
    add_chk("R8", 40'hF0F0F0F0F0, 40'h0F0F000F0F, 1'b0);
    add_chk("R8", '0, '0, 1'b0);
  endtask

  task automatic t_generate;
    for (int k = 0; k < W / SW; k++) begin
      logic [W-1:0] t;
      t = 40'd1 << (k * SW + SW - 1);
      add_chk("R4", t, t, 1'b0);
    end
    add_chk("R5", 40'h8000000000, 40'h8000000000, 1'b0);
    check("R5", {40'd0, c_out}, 41'd1);
    add_chk("R5", 40'h7FFFFFFFFF, 40'h0000000001, 1'b0);
    check("R5", {40'd0, c_out}, 41'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] a;
      logic [W-1:0] b;
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      add_chk("R1", a, b, 1'($urandom() & 1));
    end
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; a_in = '0; b_in = '0; c_in = 1'b0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_wrap();
    t_boundary();
    t_nocarry();
    t_generate();
    t_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule